// File: doc/BRIEF.md
# Serial NOR Region Erase Sequencer

This block erases a region of a serial NOR flash given as a start offset and a byte count. It drives a byte-wide command port that feeds a separate SPI shift engine. Each erase unit goes through the same steps: poll the status register until the device is idle, set the write-enable latch and confirm it, then send an erase opcode followed by a 3-byte or 4-byte address. The unit is a whole block when the current offset is block aligned and at least one block remains; otherwise it is a sector. Once the last unit has been handled, the block waits for the device to go idle one final time and then raises `done`.

When `skip_blank` is set at start, every unit is first read back in fixed chunks and checked one 32-bit word at a time. If every word in the unit reads as all ones, no erase is issued for that unit. If the engine flags a failed read during this check, the check is dropped and the unit is erased anyway. A status poll that sees the device still busy waits `POLL_GAP` cycles before it reads again. The poll gives up with a timeout code once more than `wip_limit` cycles have passed since that wait began.

Top module: `nor_erase_seq`

## Requirements
- R1: A start whose offset or size is not a multiple of the sector size (parameter, 4096 by default), or whose size is below one sector, produces `done` on the next cycle with `err` = 1. It starts no frame on the command port.
- R2: Each unit uses the block-erase opcode (0xD8) when the current offset is a multiple of the block size (65536 by default) and the remaining size is at least one block. Otherwise it uses the sector-erase opcode (0x20). The offset then advances by the size of that unit.
- R3: Every erase frame and read frame carries its address most significant byte first, in 4 bytes when `addr4` is 1 and in 3 bytes when it is 0. An erase frame is exactly the opcode followed by the address.
- R4: Before every erase the block sends status reads (frame 0x05 plus one data byte, busy flag in bit 0). It repeats them every `POLL_GAP` cycles until bit 0 reads 0.
- R5: After a status read shows the device busy and the gap has elapsed, if more than `wip_limit` cycles have passed since that wait began, the block ends with `err` = 2. A status read that shows the device idle is accepted even after the deadline. Each wait starts its count from zero.
- R6: Each erase is preceded by a write-enable frame (0x06) and a status read. If bit 1 of that status is 0, the block ends with `err` = 3 and sends no erase.
- R7: With `skip_blank` set, each unit is read with opcode 0x03 in chunks of `CHUNK` bytes and compared word by word against 0xFFFFFFFF. A unit that reads as all ones gets no erase, and the block moves on to the next unit.
- R8: If `bus_fail` is high on any data byte of a blank-check read, that unit is erased as if it had not been blank.
- R9: After the last unit the block makes one more wait for the device to go idle. `done` with `err` = 0 follows the first status read that shows bit 0 clear.
- R10: `bus_req` stays high with `bus_wdata` and `bus_last` stable until `bus_ack`. `bus_last` marks the final byte of each frame. Data-phase bytes are sent as 0xFF. `bus_req` is low while the block is idle.
- R11: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse. `err` keeps its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| offset | input | 32 | Byte offset of the region |
| size | input | 32 | Byte length of the region |
| addr4 | input | 1 | 1: 4-byte addresses, 0: 3-byte addresses |
| skip_blank | input | 1 | Read units first and skip the ones already blank |
| wip_limit | input | 32 | Cycle deadline for each idle wait |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 invalid, 2 timeout, 3 write-enable not latched |
| bus_req | output | 1 | Byte offered to the shift engine |
| bus_wdata | output | 8 | Byte to shift out |
| bus_last | output | 1 | Final byte of the frame; chip select drops after it |
| bus_ack | input | 1 | Byte exchanged |
| bus_rdata | input | 8 | Byte shifted in during the exchange |
| bus_fail | input | 1 | Read failure on this byte |

## Verification
The deadline test and the idle test can meet on the same status read: by the time that read completes, the wait counter may already be past `wip_limit`. The bench sets this up with a device model that reports busy once and a deadline of 12 cycles. That deadline sits between the counter value at the first post-gap check and the value at the read that comes back idle. The run must end without a timeout and with the erase issued. The same deadline is then reused on a two-sector request to show that each wait starts counting from zero, and a stuck busy flag with a deadline of 2 must produce code 2 with no erase sent.

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int SECT_LOG2 = 12,
  parameter int BLK_LOG2  = 16,
  parameter int CHUNK     = 16,
  parameter int POLL_GAP  = 8,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_SECT = 8'h20,
  parameter logic [7:0] OP_BLK  = 8'hD8,
  parameter logic [7:0] OP_READ = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] offset,
  input  logic [31:0] size,
  input  logic        addr4,
  input  logic        skip_blank,
  input  logic [31:0] wip_limit,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err,
  output logic        bus_req,
  output logic [7:0]  bus_wdata,
  output logic        bus_last,
  input  logic        bus_ack,
  input  logic [7:0]  bus_rdata,
  input  logic        bus_fail
);
  localparam logic [31:0] SECT  = 32'd1 << SECT_LOG2;
  localparam logic [31:0] BLK   = 32'd1 << BLK_LOG2;
  localparam logic [31:0] CHK   = 32'(CHUNK);
  localparam logic [15:0] GAPM1 = 16'(POLL_GAP - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} state_t;
  typedef enum logic [2:0] {P_STAT, P_WREN, P_WEL, P_ERASE, P_READ} purp_t;

  state_t      st;
  purp_t       purp;
  logic [7:0]  fop;
  logic [2:0]  fnad;
  logic [15:0] fnrd, idx, gcnt;
  logic [31:0] faddr, off, rem, coff, cleft, wcnt;
  logic        a4, skp, blk, fin, bad;
  logic [23:0] wsh;

  wire [15:0] ftot     = 16'd1 + 16'(fnad) + fnrd;
  wire        is_data  = idx > 16'(fnad);
  wire        fire     = bus_req && bus_ack;
  wire [1:0]  dlo      = 2'(idx - 16'(fnad));
  wire        word_end = is_data && dlo == 2'd0;
  wire        bad_nx   = bad || (is_data && bus_fail) ||
                         (word_end && {wsh, bus_rdata} != 32'hFFFF_FFFF);
  wire [31:0] usz      = blk ? BLK : SECT;
  wire [31:0] rem_nx   = rem - usz;
  wire        pick_blk = ((off & (BLK - 32'd1)) == 32'd0) && rem >= BLK;
  wire [2:0]  nad      = a4 ? 3'd4 : 3'd3;
  wire        req_bad  = ((offset & (SECT - 32'd1)) != 32'd0) ||
                         ((size & (SECT - 32'd1)) != 32'd0) || size < SECT;
  wire [1:0]  bsel     = 2'(fnad - idx[2:0]);
  wire [31:0] ash      = faddr >> {bsel, 3'b000};

  assign busy     = st != S_IDLE;
  assign bus_req  = st == S_XFER;
  assign bus_last = idx == ftot - 16'd1;

  always_comb begin
    if (idx == 16'd0)  bus_wdata = fop;
    else if (!is_data) bus_wdata = ash[7:0];
    else               bus_wdata = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; purp <= P_STAT; fop <= 8'h00; fnad <= 3'd0; fnrd <= 16'd0;
      idx <= 16'd0; gcnt <= 16'd0; faddr <= 32'd0; off <= 32'd0; rem <= 32'd0;
      coff <= 32'd0; cleft <= 32'd0; wcnt <= 32'd0; a4 <= 1'b0; skp <= 1'b0;
      blk <= 1'b0; fin <= 1'b0; bad <= 1'b0; wsh <= 24'd0; done <= 1'b0; err <= 2'd0;
    end else begin
      done <= 1'b0;
      if (wcnt != '1) wcnt <= wcnt + 32'd1;
      case (st)
        S_IDLE: if (start) begin
          err <= 2'd0;
          if (req_bad) begin
            err <= 2'd1; done <= 1'b1;
          end else begin
            off <= offset; rem <= size; a4 <= addr4; skp <= skip_blank; fin <= 1'b0;
            wcnt <= 32'd0; st <= S_XFER; idx <= 16'd0;
            purp <= P_STAT; fop <= OP_RDSR; fnad <= 3'd0; fnrd <= 16'd1;
          end
        end
        S_GAP: begin
          gcnt <= gcnt + 16'd1;
          if (gcnt == GAPM1) begin
            if (wcnt > wip_limit) begin
              err <= 2'd2; done <= 1'b1; st <= S_IDLE;
            end else begin
              st <= S_XFER; idx <= 16'd0;
              purp <= P_STAT; fop <= OP_RDSR; fnad <= 3'd0; fnrd <= 16'd1;
            end
          end
        end
        S_XFER: if (fire) begin
          idx <= idx + 16'd1;
          if (is_data) wsh <= {wsh[15:0], bus_rdata};
          if (purp == P_READ) bad <= bad_nx;
          if (bus_last) begin
            idx <= 16'd0;
            case (purp)
              P_STAT: begin
                if (bus_rdata[0]) begin
                  st <= S_GAP; gcnt <= 16'd0;
                end else if (fin) begin
                  done <= 1'b1; st <= S_IDLE;
                end else begin
                  blk <= pick_blk;
                  if (skp) begin
                    coff <= off; cleft <= pick_blk ? BLK : SECT; bad <= 1'b0;
                    purp <= P_READ; fop <= OP_READ; fnad <= nad; fnrd <= 16'(CHUNK);
                    faddr <= off;
                  end else begin
                    purp <= P_WREN; fop <= OP_WREN; fnad <= 3'd0; fnrd <= 16'd0;
                  end
                end
              end
              P_WREN: begin
                purp <= P_WEL; fop <= OP_RDSR; fnad <= 3'd0; fnrd <= 16'd1;
              end
              P_WEL: begin
                if (!bus_rdata[1]) begin
                  err <= 2'd3; done <= 1'b1; st <= S_IDLE;
                end else begin
                  purp <= P_ERASE; fop <= blk ? OP_BLK : OP_SECT; fnad <= nad;
                  fnrd <= 16'd0; faddr <= off;
                end
              end
              P_READ: begin
                if (bad_nx) begin
                  purp <= P_WREN; fop <= OP_WREN; fnad <= 3'd0; fnrd <= 16'd0;
                end else if (cleft == CHK) begin
                  off <= off + usz; rem <= rem_nx; fin <= rem_nx == 32'd0; wcnt <= 32'd0;
                  purp <= P_STAT; fop <= OP_RDSR; fnad <= 3'd0; fnrd <= 16'd1;
                end else begin
                  coff <= coff + CHK; cleft <= cleft - CHK; faddr <= coff + CHK;
                end
              end
              P_ERASE: begin
                off <= off + usz; rem <= rem_nx; fin <= rem_nx == 32'd0; wcnt <= 32'd0;
                purp <= P_STAT; fop <= OP_RDSR; fnad <= 3'd0; fnrd <= 16'd1;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk #(
  parameter int SECT_LOG2 = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] offset,
  input logic        busy,
  input logic        done,
  input logic [1:0]  err,
  input logic        bus_req,
  input logic [7:0]  bus_wdata,
  input logic        bus_last,
  input logic        bus_ack
);
  p_inval_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && offset[SECT_LOG2-1:0] != '0) |=> (done && err == 2'd1 && !busy));

  p_hold_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_wdata) && $stable(bus_last)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 2'd0 && $past(err) == 2'd0) |-> done);
endmodule

bind nor_erase_seq nor_erase_seq_chk #(.SECT_LOG2(SECT_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .busy(busy),
  .done(done), .err(err), .bus_req(bus_req), .bus_wdata(bus_wdata),
  .bus_last(bus_last), .bus_ack(bus_ack)
);

// File: tb/nor_erase_seq_test.sv
`timescale 1ns/1ps
module nor_erase_seq_test;
  localparam int SL = 8, BL = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, addr4 = 1'b0, skip_blank = 1'b0;
  logic [31:0] offset = 32'd0, size = 32'd0, wip_limit = 32'd1000;
  logic busy, done, bus_req, bus_last;
  logic [1:0] err;
  logic [7:0] bus_wdata;
  logic bus_ack = 1'b0, bus_fail = 1'b0;
  logic [7:0] bus_rdata = 8'hFF;

  always #4 clk = ~clk;

  nor_erase_seq #(.SECT_LOG2(SL), .BLK_LOG2(BL), .CHUNK(16), .POLL_GAP(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .size(size),
    .addr4(addr4), .skip_blank(skip_blank), .wip_limit(wip_limit),
    .busy(busy), .done(done), .err(err), .bus_req(bus_req), .bus_wdata(bus_wdata),
    .bus_last(bus_last), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_fail(bus_fail));

  // flash device model
  int bidx = 0, mnad = 0, busy_left = 0, busy_reads = 2;
  int n_erase = 0, n_blk = 0, n_frames = 0, first_len = 0, seq_bad = 0, wd_bad = 0, post_rd = 0;
  logic [7:0] cur_op = 8'h00;
  logic [31:0] cur_addr = 32'd0, first_addr = 32'd0, a;
  logic wel = 1'b0, seen_clear = 1'b0, stuck = 1'b0, wel_broken = 1'b0, fail_rd = 1'b0, wipnow;
  logic [31:0] dirty_lo = 32'h1000, dirty_hi = 32'h1004;

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (rst_n && bus_req) begin
      bus_ack = 1'b1; bus_fail = 1'b0; bus_rdata = 8'hFF;
      if (bidx == 0) begin
        cur_op = bus_wdata; cur_addr = 32'd0;
        mnad = (bus_wdata == 8'h03 || bus_wdata == 8'h20 || bus_wdata == 8'hD8) ? (addr4 ? 4 : 3) : 0;
      end else if (bidx <= mnad) cur_addr = {cur_addr[23:0], bus_wdata};
      else begin
        if (bus_wdata != 8'hFF) wd_bad++;
        if (cur_op == 8'h05) begin
          wipnow = stuck || busy_left > 0;
          bus_rdata = {6'd0, wel, wipnow};
          if (wipnow) begin if (!stuck) busy_left--; end
          else if (!wel) seen_clear = 1'b1;
          post_rd++;
        end else if (cur_op == 8'h03) begin
          a = cur_addr + 32'(bidx - 1 - mnad);
          bus_rdata = (a >= dirty_lo && a < dirty_hi) ? 8'h00 : 8'hFF;
          bus_fail = fail_rd;
        end
      end
      if (bus_last) begin
        n_frames++;
        if (cur_op == 8'h06 && !wel_broken) wel = 1'b1;
        if (cur_op == 8'h20 || cur_op == 8'hD8) begin
          n_erase++;
          if (cur_op == 8'hD8) n_blk++;
          if (n_erase == 1) begin first_addr = cur_addr; first_len = bidx + 1; end
          if (!seen_clear || !wel) seq_bad++;
          seen_clear = 1'b0; wel = 1'b0; busy_left = busy_reads; post_rd = 0;
        end
        bidx = 0;
      end else bidx++;
    end
  end

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    n_erase = 0; n_blk = 0; n_frames = 0; first_len = 0; seq_bad = 0; wd_bad = 0;
    post_rd = 0; first_addr = 32'd0; seen_clear = 1'b0; wel = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] o, input logic [31:0] s, input logic f4,
                        input logic sk, output logic busy_seen);
    int cyc;
    offset = o; size = s; addr4 = f4; skip_blank = sk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    cyc = 0;
    while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: actual no done expected done");
    end
  endtask

  typedef struct packed {
    logic [31:0] off; logic [31:0] sz;
    logic a4; logic sk; logic fl; logic [1:0] er;
    logic [7:0] ne; logic [7:0] nb; logic [31:0] fa;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{32'h000, 32'h100, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1, 8'd0, 32'h000},
    '{32'h000, 32'h400, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1, 8'd1, 32'h000},
    '{32'h100, 32'h400, 1'b1, 1'b0, 1'b0, 2'd0, 8'd4, 8'd0, 32'h100},
    '{32'h400, 32'h900, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3, 8'd2, 32'h400},
    '{32'h300, 32'h500, 1'b1, 1'b0, 1'b0, 2'd0, 8'd2, 8'd1, 32'h300},
    '{32'h080, 32'h100, 1'b0, 1'b0, 1'b0, 2'd1, 8'd0, 8'd0, 32'h000},
    '{32'h000, 32'h180, 1'b0, 1'b0, 1'b0, 2'd1, 8'd0, 8'd0, 32'h000},
    '{32'h000, 32'h000, 1'b0, 1'b0, 1'b0, 2'd1, 8'd0, 8'd0, 32'h000},
    '{32'hE00, 32'h400, 1'b0, 1'b1, 1'b0, 2'd0, 8'd1, 8'd0, 32'h1000},
    '{32'hC00, 32'h800, 1'b1, 1'b1, 1'b0, 2'd0, 8'd1, 8'd1, 32'h1000},
    '{32'h200, 32'h100, 1'b0, 1'b1, 1'b1, 2'd0, 8'd1, 8'd0, 32'h200},
    '{32'h000, 32'h400, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0, 8'd0, 32'h000}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic bs;
    repeat (3) @(negedge clk);
    // R11 / R10: reset state
    chk("R11 busy at reset", 32'(busy), 32'd0);
    chk("R11 done at reset", 32'(done), 32'd0);
    chk("R11 err at reset", 32'(err), 32'd0);
    chk("R10 bus_req at reset", 32'(bus_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      clear_model();
      fail_rd = VEC[i].fl;
      run_op(VEC[i].off, VEC[i].sz, VEC[i].a4, VEC[i].sk, bs);
      chk($sformatf("R1/R6 err vec%0d", i), 32'(err), 32'(VEC[i].er));
      chk($sformatf("R2/R7/R8 erase count vec%0d", i), 32'(n_erase), 32'(VEC[i].ne));
      chk($sformatf("R2 block count vec%0d", i), 32'(n_blk), 32'(VEC[i].nb));
      chk($sformatf("R4/R6 sequence vec%0d", i), 32'(seq_bad), 32'd0);
      chk($sformatf("R10 data bytes vec%0d", i), 32'(wd_bad), 32'd0);
      if (VEC[i].er == 2'd1) begin
        chk($sformatf("R1 no frames vec%0d", i), 32'(n_frames), 32'd0);
      end else begin
        chk($sformatf("R11 busy after start vec%0d", i), 32'(bs), 32'd1);
        if (VEC[i].ne != 8'd0) begin
          chk($sformatf("R3 first addr vec%0d", i), first_addr, VEC[i].fa);
          chk($sformatf("R3 frame length vec%0d", i), 32'(first_len), VEC[i].a4 ? 32'd5 : 32'd4);
        end
        if (!VEC[i].sk)
          chk($sformatf("R9 final polls vec%0d", i), 32'(post_rd), 32'(busy_reads + 1));
      end
      @(negedge clk);
      chk($sformatf("R11 done pulse vec%0d", i), 32'(done), 32'd0);
      chk($sformatf("R11 err held vec%0d", i), 32'(err), 32'(VEC[i].er));
      fail_rd = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R6: write-enable latch never sets
    clear_model(); wel_broken = 1'b1;
    run_op(32'h0, 32'h100, 1'b0, 1'b0, bs);
    chk("R6 wel error", 32'(err), 32'd3);
    chk("R6 no erase", 32'(n_erase), 32'd0);
    wel_broken = 1'b0;
    repeat (2) @(negedge clk);

    // R5: stuck busy with short deadline
    clear_model(); stuck = 1'b1; wip_limit = 32'd2;
    run_op(32'h0, 32'h100, 1'b0, 1'b0, bs);
    chk("R5 timeout", 32'(err), 32'd2);
    chk("R5 no erase on timeout", 32'(n_erase), 32'd0);
    stuck = 1'b0;
    repeat (2) @(negedge clk);

    // R5: idle status arrives after deadline passed; restart per wait
    clear_model(); busy_reads = 1; busy_left = 1; wip_limit = 32'd12;
    run_op(32'h0, 32'h200, 1'b0, 1'b0, bs);
    chk("R5 clear wins over deadline", 32'(err), 32'd0);
    chk("R5 restart each wait", 32'(n_erase), 32'd2);
    chk("R9 final wait", 32'(post_rd), 32'd2);

    finish_run();
  end
endmodule